// File: doc/BRIEF.md
# Background-Difference Binariser with Contour Overlay

This block sits in a video path on the display clock. Each cycle it can accept one pixel of the live frame and the matching pixel of a stored background frame. For each pixel it takes the absolute difference of each colour channel and averages the three differences into one grey level. It then compares that level against a programmable threshold, which gives a one-bit foreground mask.

A foreground pixel lies on a contour when a neighbour to its left, to its right or above it belongs to the background. A one-line mask store supplies the pixel above. Contour pixels are painted pure red. All other pixels show either the black-and-white mask or the untouched live colour, as a mode input selects.

The result leaves a fixed three cycles after the pixel enters. The valid, start-of-line and start-of-frame flags travel with it and carry the same delay. Within a frame, lines must all have the same length, no longer than `LINE_W`. The pixels of one line must arrive on consecutive cycles, although idle cycles may separate lines and frames. The threshold and mode inputs are meant to stay constant for a whole frame.

Top module: `bgdiff_overlay`

## Requirements
- R1: The grey level of a pixel is floor((|cr-br| + |cg-bg| + |cb-bb|) / 3), where c is the live pixel and b the background pixel. The difference is taken in absolute value, so it does not matter which of the two pixels is larger.
- R2: A pixel is foreground, and `out_mask` is 1, exactly when its grey level is strictly greater than `thresh`. A grey level equal to `thresh` counts as background.
- R3: Each pixel's result appears exactly 3 cycles after it is presented. `out_valid`, `out_sol` and `out_sof` equal `in_valid`, `in_sol` and `in_sof` from 3 cycles earlier, so every pixel presented comes out once, in order.
- R4: With `disp_mode` = 1 (mask view), a pixel that is not on a contour is shown white when it is foreground (every channel at its maximum code) and black when it is background (every channel 0).
- R5: With `disp_mode` = 0 (colour view), a pixel that is not on a contour is shown with the live frame's R, G and B values unchanged.
- R6: A foreground pixel with a background neighbour on its left, on its right or directly above it is a contour pixel. In either mode it is shown as red at its maximum code, with green and blue at 0, and `out_mask` stays 1.
- R7: Positions outside the image never create a contour. This covers the left of the first pixel in a line and the right of the last pixel in a line, where the next cycle is idle or starts a new line. It also covers the space above the first line of a frame.
- R8: The neighbour above is the mask of the pixel in the same column of the previous line of the same frame.
- R9: Out of reset, and on every cycle with `out_valid` = 0, `out_mask` and all three colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pixel pair is presented this cycle |
| in_sol | input | 1 | The presented pixel is the first of its line |
| in_sof | input | 1 | The presented pixel is the first of its frame (also first of its line) |
| cur_r | input | CW | Live frame red |
| cur_g | input | CW | Live frame green |
| cur_b | input | CW | Live frame blue |
| bg_r | input | CW | Background red |
| bg_g | input | CW | Background green |
| bg_b | input | CW | Background blue |
| thresh | input | CW | Foreground threshold on the grey level |
| disp_mode | input | 1 | 0 = colour view, 1 = mask view |
| out_valid | output | 1 | Output pixel is valid |
| out_sol | output | 1 | Output pixel starts a line |
| out_sof | output | 1 | Output pixel starts a frame |
| out_r | output | CW | Display red |
| out_g | output | CW | Display green |
| out_b | output | CW | Display blue |
| out_mask | output | 1 | Foreground mask bit |

## Verification
The contour override and the mode selection act on the same output pixel in the same cycle. The rule is that red wins in both modes, while non-contour pixels follow the mode. A solid blob is driven in colour view, and a notched frame, an all-foreground frame and a threshold-boundary frame are driven in mask view. Every output pixel is then compared against a neighbourhood model in the bench. A second collision happens at a line end: the right-neighbour lookahead meets either the next line's first pixel or an idle cycle. To provoke this, all-foreground frames are run both with and without idle gaps between lines, and any red pixel at an edge is a failure.

// File: rtl/bgdiff_pkg.sv
package bgdiff_pkg;
  typedef enum logic {
    DISP_COLOUR = 1'b0,
    DISP_MASK   = 1'b1
  } disp_mode_e;
endpackage

// File: rtl/bgdiff_diff_stage.sv
module bgdiff_diff_stage #(
  parameter int CW     = 10,
  parameter int LINE_W = 640
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic              in_sof,
  input  logic [CW-1:0]     cur_r,
  input  logic [CW-1:0]     cur_g,
  input  logic [CW-1:0]     cur_b,
  input  logic [CW-1:0]     bg_r,
  input  logic [CW-1:0]     bg_g,
  input  logic [CW-1:0]     bg_b,
  output logic              s1_valid,
  output logic              s1_sol,
  output logic              s1_sof,
  output logic              s1_first_row,
  output logic [$clog2(LINE_W)-1:0] s1_col,
  output logic [CW+1:0]     s1_sum,
  output logic [CW-1:0]     s1_r,
  output logic [CW-1:0]     s1_g,
  output logic [CW-1:0]     s1_b
);
  localparam int COL_W = $clog2(LINE_W);
  localparam int SUM_W = CW + 2;

  function automatic logic [CW-1:0] abs_diff(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [SUM_W-1:0] diff_sum(
    input logic [CW-1:0] ar, input logic [CW-1:0] ag, input logic [CW-1:0] ab,
    input logic [CW-1:0] br, input logic [CW-1:0] bg, input logic [CW-1:0] bb);
    return {2'b00, abs_diff(ar, br)} + {2'b00, abs_diff(ag, bg)} + {2'b00, abs_diff(ab, bb)};
  endfunction

  logic [COL_W-1:0] col_q;
  logic             first_row_q;
  logic             line_start;
  logic [COL_W-1:0] pix_col;
  logic             pix_first_row;

  assign line_start    = in_sol | in_sof;
  assign pix_col       = line_start ? '0 : col_q;
  assign pix_first_row = in_sof ? 1'b1 : (in_sol ? 1'b0 : first_row_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q        <= '0;
      first_row_q  <= 1'b1;
      s1_valid     <= 1'b0;
      s1_sol       <= 1'b0;
      s1_sof       <= 1'b0;
      s1_first_row <= 1'b1;
      s1_col       <= '0;
      s1_sum       <= '0;
      s1_r         <= '0;
      s1_g         <= '0;
      s1_b         <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sol   <= in_valid & line_start;
      s1_sof   <= in_valid & in_sof;
      if (in_valid) begin
        col_q        <= pix_col + COL_W'(1);
        first_row_q  <= pix_first_row;
        s1_col       <= pix_col;
        s1_first_row <= pix_first_row;
        s1_sum       <= diff_sum(cur_r, cur_g, cur_b, bg_r, bg_g, bg_b);
        s1_r         <= cur_r;
        s1_g         <= cur_g;
        s1_b         <= cur_b;
      end
    end
  end
endmodule

// File: rtl/bgdiff_mask_contour.sv
module bgdiff_mask_contour #(
  parameter int CW     = 10,
  parameter int LINE_W = 640
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     thresh,
  input  logic              s1_valid,
  input  logic              s1_sol,
  input  logic              s1_sof,
  input  logic              s1_first_row,
  input  logic [$clog2(LINE_W)-1:0] s1_col,
  input  logic [CW+1:0]     s1_sum,
  input  logic [CW-1:0]     s1_r,
  input  logic [CW-1:0]     s1_g,
  input  logic [CW-1:0]     s1_b,
  output logic              s2_valid,
  output logic              s2_sol,
  output logic              s2_sof,
  output logic              s2_mask,
  output logic [CW-1:0]     s2_r,
  output logic [CW-1:0]     s2_g,
  output logic [CW-1:0]     s2_b,
  output logic              contour
);
  localparam int COL_W = $clog2(LINE_W);
  localparam int SUM_W = CW + 2;
  localparam int SHIFT = CW + 6;
  localparam int PROD_W = SUM_W + SHIFT;
  localparam logic [SHIFT-1:0] RECIP3 = SHIFT'(((1 << SHIFT) + 2) / 3);

  // Mean of three without a divider: multiply by a rounded-up reciprocal.
  function automatic logic [CW-1:0] grey_of(input logic [SUM_W-1:0] sum);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(sum) * PROD_W'(RECIP3);
    return prod[SHIFT +: CW];
  endfunction

  logic             fg_now;
  logic [COL_W-1:0] s2_col;
  logic             s2_first_row;
  logic             s2_left;
  logic             above_mask;
  logic             left_bg;
  logic             right_bg;
  logic             above_bg;
  logic             line_mem [LINE_W];

  assign fg_now = s1_valid && (grey_of(s1_sum) > thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid     <= 1'b0;
      s2_sol       <= 1'b0;
      s2_sof       <= 1'b0;
      s2_mask      <= 1'b0;
      s2_left      <= 1'b0;
      s2_col       <= '0;
      s2_first_row <= 1'b1;
      s2_r         <= '0;
      s2_g         <= '0;
      s2_b         <= '0;
    end else begin
      s2_valid     <= s1_valid;
      s2_sol       <= s1_sol;
      s2_sof       <= s1_sof;
      s2_mask      <= fg_now;
      s2_left      <= s2_mask;
      s2_col       <= s1_col;
      s2_first_row <= s1_first_row;
      s2_r         <= s1_r;
      s2_g         <= s1_g;
      s2_b         <= s1_b;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) line_mem[s2_col] <= s2_mask;
  end

  assign above_mask = line_mem[s2_col];
  assign left_bg    = !s2_sol && !s2_left;
  assign right_bg   = s1_valid && !s1_sol && !fg_now;
  assign above_bg   = !s2_first_row && !above_mask;
  assign contour    = s2_valid && s2_mask && (left_bg || right_bg || above_bg);

  // R7: the left-neighbour register is only meaningful if pixels of a line are back to back
  assert_line_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_sol) |-> $past(s2_valid))
    else $error("pixel inside a line followed an idle cycle");
endmodule

// File: rtl/bgdiff_display.sv
module bgdiff_display
  import bgdiff_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_mode,
  input  logic          s2_valid,
  input  logic          s2_sol,
  input  logic          s2_sof,
  input  logic          s2_mask,
  input  logic [CW-1:0] s2_r,
  input  logic [CW-1:0] s2_g,
  input  logic [CW-1:0] s2_b,
  input  logic          contour,
  output logic          out_valid,
  output logic          out_sol,
  output logic          out_sof,
  output logic          out_mask,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b
);
  localparam logic [CW-1:0] FULL = '1;

  disp_mode_e mode_e;
  assign mode_e = disp_mode_e'(disp_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_mask  <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= s2_valid;
      out_sol   <= s2_sol;
      out_sof   <= s2_sof;
      out_mask  <= s2_valid & s2_mask;
      if (!s2_valid) begin
        out_r <= '0; out_g <= '0; out_b <= '0;
      end else if (contour) begin
        out_r <= FULL; out_g <= '0; out_b <= '0;
      end else if (mode_e == DISP_MASK) begin
        out_r <= {CW{s2_mask}}; out_g <= {CW{s2_mask}}; out_b <= {CW{s2_mask}};
      end else begin
        out_r <= s2_r; out_g <= s2_g; out_b <= s2_b;
      end
    end
  end

  assert_contour_red_R6: assert property (@(posedge clk) disable iff (!rst_n)
    contour |=> (out_r == FULL && out_g == '0 && out_b == '0 && out_mask))
    else $error("contour pixel not shown red");

  assert_mask_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !contour && mode_e == DISP_MASK) |=>
      (out_r == {CW{$past(s2_mask)}} && out_g == out_r && out_b == out_r))
    else $error("mask view pixel not black or white");

  assert_colour_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !contour && mode_e == DISP_COLOUR) |=>
      (out_r == $past(s2_r) && out_g == $past(s2_g) && out_b == $past(s2_b)))
    else $error("colour view pixel altered");

  assert_idle_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_mask && out_r == '0 && out_g == '0 && out_b == '0))
    else $error("outputs not dark on an idle cycle");
endmodule

// File: rtl/bgdiff_overlay.sv
module bgdiff_overlay #(
  parameter int CW     = 10,
  parameter int LINE_W = 640
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_sof,
  input  logic [CW-1:0] cur_r,
  input  logic [CW-1:0] cur_g,
  input  logic [CW-1:0] cur_b,
  input  logic [CW-1:0] bg_r,
  input  logic [CW-1:0] bg_g,
  input  logic [CW-1:0] bg_b,
  input  logic [CW-1:0] thresh,
  input  logic          disp_mode,
  output logic          out_valid,
  output logic          out_sol,
  output logic          out_sof,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b,
  output logic          out_mask
);
  localparam int COL_W = $clog2(LINE_W);

  logic             s1_valid, s1_sol, s1_sof, s1_first_row;
  logic [COL_W-1:0] s1_col;
  logic [CW+1:0]    s1_sum;
  logic [CW-1:0]    s1_r, s1_g, s1_b;
  logic             s2_valid, s2_sol, s2_sof, s2_mask, contour;
  logic [CW-1:0]    s2_r, s2_g, s2_b;

  bgdiff_diff_stage #(.CW(CW), .LINE_W(LINE_W)) u_diff (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
    .cur_r(cur_r), .cur_g(cur_g), .cur_b(cur_b), .bg_r(bg_r), .bg_g(bg_g), .bg_b(bg_b),
    .s1_valid(s1_valid), .s1_sol(s1_sol), .s1_sof(s1_sof), .s1_first_row(s1_first_row),
    .s1_col(s1_col), .s1_sum(s1_sum), .s1_r(s1_r), .s1_g(s1_g), .s1_b(s1_b));

  bgdiff_mask_contour #(.CW(CW), .LINE_W(LINE_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .thresh(thresh),
    .s1_valid(s1_valid), .s1_sol(s1_sol), .s1_sof(s1_sof), .s1_first_row(s1_first_row),
    .s1_col(s1_col), .s1_sum(s1_sum), .s1_r(s1_r), .s1_g(s1_g), .s1_b(s1_b),
    .s2_valid(s2_valid), .s2_sol(s2_sol), .s2_sof(s2_sof), .s2_mask(s2_mask),
    .s2_r(s2_r), .s2_g(s2_g), .s2_b(s2_b), .contour(contour));

  bgdiff_display #(.CW(CW)) u_disp (
    .clk(clk), .rst_n(rst_n), .disp_mode(disp_mode),
    .s2_valid(s2_valid), .s2_sol(s2_sol), .s2_sof(s2_sof), .s2_mask(s2_mask),
    .s2_r(s2_r), .s2_g(s2_g), .s2_b(s2_b), .contour(contour),
    .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_mask(out_mask),
    .out_r(out_r), .out_g(out_g), .out_b(out_b));

  // Assertion support: flags seen at the input, three edges deep
  logic [2:0] hist_v, hist_l, hist_f;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_v <= '0; hist_l <= '0; hist_f <= '0;
    end else begin
      hist_v <= {hist_v[1:0], in_valid};
      hist_l <= {hist_l[1:0], in_valid & (in_sol | in_sof)};
      hist_f <= {hist_f[1:0], in_valid & in_sof};
    end
  end

  assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == hist_v[2]) && (out_sol == hist_l[2]) && (out_sof == hist_f[2]))
    else $error("output flags not three cycles behind input");
endmodule

// File: tb/sim_bgdiff_overlay.sv
module sim_bgdiff_overlay;
  localparam int PERIOD = 10;
  localparam int CW = 10;
  localparam int LW = 8;
  localparam int W = 6;
  localparam int H = 3;
  localparam int N = W * H;
  localparam int MAXV = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [CW-1:0] cur_r = '0, cur_g = '0, cur_b = '0, bg_r = '0, bg_g = '0, bg_b = '0;
  logic [CW-1:0] thresh = '0;
  logic disp_mode = 1'b0;
  logic out_valid, out_sol, out_sof, out_mask;
  logic [CW-1:0] out_r, out_g, out_b;

  bgdiff_overlay #(.CW(CW), .LINE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
    .cur_r(cur_r), .cur_g(cur_g), .cur_b(cur_b), .bg_r(bg_r), .bg_g(bg_g), .bg_b(bg_b),
    .thresh(thresh), .disp_mode(disp_mode), .out_valid(out_valid), .out_sol(out_sol),
    .out_sof(out_sof), .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_mask(out_mask));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int fc [3][N];
  int fb [3][N];
  int cap_r [N], cap_g [N], cap_b [N], cap_m [N], cap_l [N], cap_f [N];
  int ncap = 0, first_cyc = 0, start_cyc = 0;
  bit cap_en = 1'b0;

  always @(negedge clk) begin
    if (cap_en && out_valid) begin
      if (ncap < N) begin
        cap_r[ncap] = out_r; cap_g[ncap] = out_g; cap_b[ncap] = out_b;
        cap_m[ncap] = out_mask; cap_l[ncap] = out_sol; cap_f[ncap] = out_sof;
      end
      if (ncap == 0) first_cyc = cyc;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit fg(input int i, input int thr);
    int s = 0;
    for (int k = 0; k < 3; k++) s += (fc[k][i] > fb[k][i]) ? fc[k][i] - fb[k][i] : fb[k][i] - fc[k][i];
    return (s / 3) > thr;
  endfunction

  function automatic bit is_edge(input int i, input int thr);
    int c = i % W;
    int r = i / W;
    if (!fg(i, thr)) return 1'b0;
    return (c > 0 && !fg(i-1, thr)) || (c < W-1 && !fg(i+1, thr)) || (r > 0 && !fg(i-W, thr));
  endfunction

  task automatic set_px(input int i, input int r, input int g, input int b,
                        input int br, input int bgv, input int bb);
    fc[0][i] = r; fc[1][i] = g; fc[2][i] = b;
    fb[0][i] = br; fb[1][i] = bgv; fb[2][i] = bb;
  endtask

  task automatic run_frame(input int thr, input bit mode, input int gap, input string mtag);
    thresh = CW'(thr); disp_mode = mode;
    ncap = 0; cap_en = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i == 0) start_cyc = cyc;
      in_valid = 1'b1; in_sol = (i % W == 0); in_sof = (i == 0);
      cur_r = CW'(fc[0][i]); cur_g = CW'(fc[1][i]); cur_b = CW'(fc[2][i]);
      bg_r = CW'(fb[0][i]); bg_g = CW'(fb[1][i]); bg_b = CW'(fb[2][i]);
      if (i % W == W-1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
        end
      end
    end
    @(negedge clk); in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
    repeat (6) @(negedge clk);
    cap_en = 1'b0;
    chk("R3", "pixel count", ncap, N);
    chk("R3", "first output cycle", first_cyc, start_cyc + 3);
    chk("R9", "idle out_valid/mask/rgb", out_valid + out_mask + out_r + out_g + out_b, 0);
    for (int i = 0; i < N && i < ncap; i++) begin
      int er, eg, eb;
      string rq;
      bit f = fg(i, thr);
      if (is_edge(i, thr)) begin
        er = MAXV; eg = 0; eb = 0; rq = "R6";
      end else if (mode) begin
        er = f ? MAXV : 0; eg = er; eb = er; rq = (i % W == 0 || i % W == W-1 || i < W) ? "R7" : "R4";
      end else begin
        er = fc[0][i]; eg = fc[1][i]; eb = fc[2][i]; rq = "R5";
      end
      chk(mtag, $sformatf("mask px%0d", i), cap_m[i], f);
      chk(rq, $sformatf("red px%0d", i), cap_r[i], er);
      chk(rq, $sformatf("green px%0d", i), cap_g[i], eg);
      chk(rq, $sformatf("blue px%0d", i), cap_b[i], eb);
      chk("R3", $sformatf("sol/sof px%0d", i), cap_l[i] * 2 + cap_f[i],
          (i % W == 0 ? 2 : 0) + (i == 0 ? 1 : 0));
    end
  endtask

  // R1 R2: floor of the mean, absolute value, strict compare
  task automatic test_threshold_floor();
    for (int i = 0; i < N; i++) begin
      case (i % 6)
        0: set_px(i, 600, 600, 600, 500, 500, 500);  // grey 100, not above 100
        1: set_px(i, 601, 600, 601, 500, 500, 500);  // sum 302, grey 100
        2: set_px(i, 601, 601, 601, 500, 500, 500);  // grey 101
        3: set_px(i, 350, 350, 350, 500, 500, 500);  // negative diffs, grey 150
        4: set_px(i, 500, 500, 804, 500, 500, 500);  // grey 101
        default: set_px(i, 500, 500, 500, 500, 500, 500);
      endcase
    end
    run_frame(100, 1'b1, 0, "R1");
  endtask

  // R5 R6: solid blob in colour view, contour overrides colour
  task automatic test_blob_colour();
    for (int i = 0; i < N; i++) begin
      if (i % W >= 1 && i % W <= 4) set_px(i, 800, 300, 50, 200, 200, 200);
      else set_px(i, 210, 190, 200, 200, 200, 200);
    end
    run_frame(50, 1'b0, 0, "R2");
    run_frame(50, 1'b1, 2, "R2");
  endtask

  // R7: all-foreground frames, no contour at image borders, with and without gaps
  task automatic test_borders();
    for (int i = 0; i < N; i++) set_px(i, 1000, 1000, 1000, 0, 0, 0);
    run_frame(10, 1'b1, 1, "R7");
    run_frame(10, 1'b1, 0, "R7");
  endtask

  // R8: notch in the first line only, contour from the line above
  task automatic test_above();
    for (int i = 0; i < N; i++) begin
      if (i == 3) set_px(i, 0, 0, 0, 0, 0, 0);
      else set_px(i, 900, 900, 900, 0, 0, 0);
    end
    run_frame(10, 1'b1, 0, "R8");
  endtask

  // R2: full-scale grey against the top thresholds
  task automatic test_full_scale();
    for (int i = 0; i < N; i++) begin
      if (i % 2 == 0) set_px(i, MAXV, MAXV, MAXV, 0, 0, 0);
      else set_px(i, 0, 0, 0, MAXV, MAXV, MAXV);
    end
    run_frame(1022, 1'b1, 0, "R2");
    run_frame(1023, 1'b1, 0, "R2");
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset outputs", out_valid + out_mask + out_r + out_g + out_b, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "post-reset idle", out_valid + out_mask + out_r + out_g + out_b + out_sol + out_sof, 0);
    test_threshold_floor();
    test_blob_colour();
    test_borders();
    test_above();
    test_full_scale();
    report();
  end
endmodule